// File: doc/BRIEF.md
# Windowed Memory Bandwidth Monitor

This block sits next to a memory controller's request and grant strobes. It counts how much traffic the controller sees. One counter takes every request strobe, one takes every grant strobe, and four filter channels each take only the grants that pass their own filter. A channel filters either by the grant's major-port number against a 32-bit port mask, or, when its sub-device mode is on, by the grant's sub-device index against a 16-bit mask. Several channels may match one grant, and each of them counts it in the same cycle.

The monitor can run free, or inside a measurement window set by a down-counting cycle timer. When the timer runs out, every counter freezes and a sticky window-done flag sets. The flag drives the interrupt line while the block is enabled. Software then reads the frozen counts, writes the flag back to clear it, clears the counters and reloads the timer to start the next window. For example, a timer loaded with one tenth of the memory clock frequency gives a 100 ms window.

All registers sit on a single-cycle word-addressed bus. The read data is registered, so it appears one cycle after the address.

Top module: `bwmon_top`

## Requirements
- R1: After reset every mapped register reads zero and `irq` is low.
- R2: Word addresses are: 0 control; 1+2c the port mask of channel c and 2+2c its sub-device mask (c = 0..3); 9 request count; 10 grant count; 11+c the count of channel c; 15 timer. The sub-device mask keeps the low 16 bits. Any other address reads zero and ignores writes. `rd_data` shows the register addressed in the previous cycle.
- R3: In port mode (port-mask bit 23 clear), an enabled channel counts a grant when the port-mask bit indexed by `gnt_port` is set.
- R4: When port-mask bit 23 is set, the channel counts a grant when the sub-device-mask bit indexed by `gnt_sub` is set, whatever the port.
- R5: Control bits 3:0 enable channels 0..3 one by one; a disabled channel never counts. A grant that matches several enabled channels adds one to each of them in that cycle.
- R6: Counting is active while control bit 31 (enable) is 1, the window-done flag is 0, and either control bit 20 (timer mode) is 0 or the timer is nonzero. While active, the request and grant counters add one per strobe. While inactive, nothing counts.
- R7: In timer mode the timer drops by one on each active cycle. Counting covers exactly as many cycles as the value loaded. When the timer goes from 1 to 0, the flag (control bit 30) sets. In free mode (bit 20 clear) the flag never sets. A timer of 0 in timer mode counts nothing.
- R8: Once the flag is set, all counters and the timer hold their values.
- R9: Writing control with bit 30 set clears the flag. Writing it with bit 30 clear leaves the flag as it was.
- R10: `irq` is high exactly when the flag and control bit 31 are both 1.
- R11: Counters saturate at all ones and never wrap.
- R12: Any write to a counter address clears that counter. A write to the timer address loads it. Writing zero to a filter register reads back zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_stb | input | 1 | One request seen this cycle |
| gnt_stb | input | 1 | One grant issued this cycle |
| gnt_port | input | 5 | Major-port number of the grant |
| gnt_sub | input | 4 | Sub-device index of the grant |
| bus_addr | input | 5 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Window-done interrupt |

## Verification
A filter that decodes the wrong bit, or a channel enable that is wired wrong, shows up as a wrong channel count at the end of a full sweep of all ports against all sub-devices. A timer that is off by one changes the request count of a window by exactly one. That count can be read one cycle after the window closes. A flag or hold fault shows at once on `irq`, or as counts that keep moving after the window has closed. A wrap in place of saturation is visible as soon as a counter passes all ones.

// File: rtl/bwmon_pkg.sv
// Package: shared constants of the bandwidth monitor (bus width, control
// bit positions, filter mode select bit). Assumes a 32-bit register bus.
package bwmon_pkg;
    localparam int DATA_W      = 32;
    localparam int CTL_EN_BIT  = 31;
    localparam int CTL_FLG_BIT = 30;
    localparam int CTL_TMR_BIT = 20;
    localparam int SUB_SEL_BIT = 23;
    localparam int SUB_W       = 16;
endpackage

// File: rtl/bwmon_sat_cnt.sv
// Module: saturating event counter. It adds one per cycle while inc is high,
// stops at all ones, and clears on clr (clr wins over inc).
// Assumes inc and clr are synchronous to clk.
module bwmon_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Count register: clear, saturating increment or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (clr)              cnt <= '0;
        else if (inc && cnt != '1) cnt <= cnt + W'(1);
    end

    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1 && !clr) |=> cnt == '1);
    a_r11_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/bwmon_chan_match.sv
// Module: grant filter of one channel. In port mode it looks up the grant's
// port in the port mask. When the mode bit of the port mask is set, it looks
// up the sub-device index in the sub-device mask instead.
// Assumes the ids are valid in the cycle gnt is high.
module bwmon_chan_match #(
    parameter int PORT_W  = 32,
    parameter int SUB_W   = 16,
    parameter int SEL_BIT = 23,
    localparam int PID_W  = $clog2(PORT_W),
    localparam int SID_W  = $clog2(SUB_W)
) (
    input  logic              en,
    input  logic              gnt,
    input  logic [PORT_W-1:0] port_mask,
    input  logic [SUB_W-1:0]  sub_mask,
    input  logic [PID_W-1:0]  port_id,
    input  logic [SID_W-1:0]  sub_id,
    output logic              hit
);
    logic sel;
    // Filter decision: pick the mask lookup by mode, then gate.
    always_comb begin
        sel = port_mask[SEL_BIT] ? sub_mask[sub_id] : port_mask[port_id];
        hit = en && gnt && sel;
    end
endmodule

// File: rtl/bwmon_window_timer.sv
// Module: window timer. It loads on ld and drops by one on each run cycle
// while nonzero. expire pulses in the cycle where it steps from 1 to 0.
// Assumes the caller drops run once the window has closed.
module bwmon_window_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         run,
    output logic [W-1:0] value,
    output logic         expire
);
    // Timer register: load, count down or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                  value <= '0;
        else if (ld)                 value <= ld_val;
        else if (run && value != '0) value <= value - W'(1);
    end

    // Expiry detect: last running cycle of the window.
    assign expire = run && !ld && (value == W'(1));
endmodule

// File: rtl/bwmon_top.sv
// Module: windowed memory bandwidth monitor. It holds the register file and
// read mux, and counts requests, grants and filtered grants per channel
// inside a timer window. At window end it sets a sticky flag that drives irq.
// Assumes single-cycle bus writes and at most one request and one grant
// per cycle.
module bwmon_top
    import bwmon_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5,
    localparam int PID_W = $clog2(DATA_W),
    localparam int SID_W = $clog2(SUB_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_stb,
    input  logic              gnt_stb,
    input  logic [PID_W-1:0]  gnt_port,
    input  logic [SID_W-1:0]  gnt_sub,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int A_CTRL  = 0;
    localparam int A_FILT  = 1;
    localparam int A_REQ   = A_FILT + 2 * NUM_CH;
    localparam int A_GNT   = A_REQ + 1;
    localparam int A_CHCNT = A_REQ + 2;
    localparam int A_TMR   = A_CHCNT + NUM_CH;

    logic              ctl_en, ctl_tmr, flag;
    logic [NUM_CH-1:0] ctl_chen;
    logic [DATA_W-1:0] port_mask [NUM_CH];
    logic [SUB_W-1:0]  sub_mask  [NUM_CH];
    logic [CNT_W-1:0]  ch_cnt    [NUM_CH];
    logic [CNT_W-1:0]  req_cnt, gnt_cnt;
    logic [DATA_W-1:0] tmr_val, rd_next;
    logic [NUM_CH-1:0] hit;
    logic              active, tmr_run, tmr_exp, ctrl_wr, tmr_wr;

    assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(A_CTRL));
    assign tmr_wr  = bus_we && (bus_addr == ADDR_W'(A_TMR));
    assign tmr_run = ctl_en && ctl_tmr && !flag;
    assign active  = ctl_en && !flag && (!ctl_tmr || tmr_val != '0);
    assign irq     = flag && ctl_en;

    // Control register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            ctl_tmr  <= 1'b0;
            ctl_chen <= '0;
        end else if (ctrl_wr) begin
            ctl_en   <= bus_wdata[CTL_EN_BIT];
            ctl_tmr  <= bus_wdata[CTL_TMR_BIT];
            ctl_chen <= bus_wdata[NUM_CH-1:0];
        end
    end

    // Window-done flag: set on expiry, cleared by writing bit 30 as one.
    always_ff @(posedge clk) begin
        if (!rst_n)                              flag <= 1'b0;
        else if (tmr_exp)                        flag <= 1'b1;
        else if (ctrl_wr && bus_wdata[CTL_FLG_BIT]) flag <= 1'b0;
    end

    // Filter mask registers of all channels.
    always_ff @(posedge clk) begin
        for (int c = 0; c < NUM_CH; c++) begin
            if (!rst_n) begin
                port_mask[c] <= '0;
                sub_mask[c]  <= '0;
            end else if (bus_we && bus_addr == ADDR_W'(A_FILT + 2 * c)) begin
                port_mask[c] <= bus_wdata;
            end else if (bus_we && bus_addr == ADDR_W'(A_FILT + 2 * c + 1)) begin
                sub_mask[c]  <= bus_wdata[SUB_W-1:0];
            end
        end
    end

    bwmon_window_timer #(.W(DATA_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .ld(tmr_wr), .ld_val(bus_wdata),
        .run(tmr_run), .value(tmr_val), .expire(tmr_exp)
    );

    bwmon_sat_cnt #(.W(CNT_W)) u_req_cnt (
        .clk(clk), .rst_n(rst_n), .clr(bus_we && bus_addr == ADDR_W'(A_REQ)),
        .inc(active && req_stb), .cnt(req_cnt)
    );

    bwmon_sat_cnt #(.W(CNT_W)) u_gnt_cnt (
        .clk(clk), .rst_n(rst_n), .clr(bus_we && bus_addr == ADDR_W'(A_GNT)),
        .inc(active && gnt_stb), .cnt(gnt_cnt)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bwmon_chan_match #(.PORT_W(DATA_W), .SUB_W(SUB_W), .SEL_BIT(SUB_SEL_BIT)) u_match (
            .en(ctl_chen[c]), .gnt(gnt_stb), .port_mask(port_mask[c]),
            .sub_mask(sub_mask[c]), .port_id(gnt_port), .sub_id(gnt_sub), .hit(hit[c])
        );
        bwmon_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(bus_we && bus_addr == ADDR_W'(A_CHCNT + c)),
            .inc(active && hit[c]), .cnt(ch_cnt[c])
        );
    end

    // Read mux: decode the word address; unmapped addresses give zero.
    always_comb begin
        rd_next = '0;
        if (bus_addr == ADDR_W'(A_CTRL)) begin
            rd_next[CTL_EN_BIT]  = ctl_en;
            rd_next[CTL_FLG_BIT] = flag;
            rd_next[CTL_TMR_BIT] = ctl_tmr;
            rd_next[NUM_CH-1:0]  = ctl_chen;
        end
        if (bus_addr == ADDR_W'(A_REQ)) rd_next = DATA_W'(req_cnt);
        if (bus_addr == ADDR_W'(A_GNT)) rd_next = DATA_W'(gnt_cnt);
        if (bus_addr == ADDR_W'(A_TMR)) rd_next = tmr_val;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(A_FILT + 2 * c))     rd_next = port_mask[c];
            if (bus_addr == ADDR_W'(A_FILT + 2 * c + 1)) rd_next = DATA_W'(sub_mask[c]);
            if (bus_addr == ADDR_W'(A_CHCNT + c))        rd_next = DATA_W'(ch_cnt[c]);
        end
    end

    // Read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end

    a_r7_flag_at_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tmr_val) == DATA_W'(1));
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(ctrl_wr && bus_wdata[CTL_FLG_BIT])) |=> flag);
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(bus_we && bus_addr == ADDR_W'(A_REQ))) |=> $stable(req_cnt));
    a_r8_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !tmr_wr) |=> $stable(tmr_val));
endmodule

// File: tb/sim_bwmon_top.sv
module sim_bwmon_top;
    localparam int CW   = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_stb = 1'b0, gnt_stb = 1'b0, bus_we = 1'b0;
    logic [4:0]  gnt_port = '0, bus_addr = '0;
    logic [3:0]  gnt_sub = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    bwmon_top #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .gnt_stb(gnt_stb),
        .gnt_port(gnt_port), .gnt_sub(gnt_sub), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_addr = 5'(a); bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        bus_addr = 5'(a);
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic clear_counts();
        for (int a = 9; a < 15; a++) wr(a, 32'hFFFF_FFFF);
    endtask

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    logic [31:0] v;
    logic [31:0] pm [4];
    logic [15:0] sm [4];
    int exp_ch [4];
    int exp_req;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            chk($sformatf("R1 reset addr %0d", a), v, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R2: unmapped addresses ignore writes and read zero
        for (int a = 16; a < 32; a++) wr(a, 32'hFFFF_FFFF);
        for (int a = 16; a < 32; a++) begin
            rd(a, v);
            chk($sformatf("R2 unmapped addr %0d", a), v, 32'h0);
        end
        rd(0, v);
        chk("R2 control untouched by unmapped writes", v, 32'h0);

        // R2/R12: filter registers, readback and clearing with zero
        pm[0] = 32'h0000_00F1; sm[0] = 16'h0000;
        pm[1] = 32'h0080_0000; sm[1] = 16'h00A5;
        pm[2] = 32'h8000_0001; sm[2] = 16'hFFFF;
        pm[3] = 32'hFF7F_FFFF; sm[3] = 16'hFFFF;
        for (int c = 0; c < 4; c++) begin
            wr(1 + 2 * c, 32'hFFFF_FFFF); wr(2 + 2 * c, 32'hFFFF_FFFF);
            rd(2 + 2 * c, v);
            chk($sformatf("R2 sub mask width ch%0d", c), v, 32'h0000_FFFF);
            wr(1 + 2 * c, 0); wr(2 + 2 * c, 0);
            rd(1 + 2 * c, v);
            chk($sformatf("R12 port mask cleared ch%0d", c), v, 32'h0);
            wr(1 + 2 * c, pm[c]); wr(2 + 2 * c, {16'hABCD, sm[c]});
            rd(1 + 2 * c, v);
            chk($sformatf("R2 port mask readback ch%0d", c), v, pm[c]);
        end

        // R3/R4/R5/R6/R11: free-mode sweep of every port against every sub-device
        wr(0, 32'h8000_000B);   // enable, free mode, channel 2 disabled
        exp_req = 0;
        for (int c = 0; c < 4; c++) exp_ch[c] = 0;
        for (int p = 0; p < 32; p++) begin
            for (int s = 0; s < 16; s++) begin
                gnt_stb = 1'b1; gnt_port = 5'(p); gnt_sub = 4'(s);
                req_stb = ((p + s) % 3 == 0);
                if (req_stb) exp_req++;
                for (int c = 0; c < 4; c++) begin
                    if (c != 2) begin
                        if (pm[c][23]) exp_ch[c] += int'(sm[c][s]);
                        else           exp_ch[c] += int'(pm[c][p]);
                    end
                end
                @(negedge clk);
            end
        end
        gnt_stb = 1'b0; req_stb = 1'b0;
        wr(0, 32'h0);
        rd(9, v);  chk("R6 request count free mode", v, 32'(sat(exp_req)));
        rd(10, v); chk("R11 grant count saturates", v, 32'(sat(512)));
        rd(11, v); chk("R3 port mode channel 0", v, 32'(sat(exp_ch[0])));
        rd(12, v); chk("R4 sub-device mode channel 1", v, 32'(sat(exp_ch[1])));
        rd(13, v); chk("R5 disabled channel 2", v, 32'h0);
        rd(14, v); chk("R5 overlapping channel 3 saturates", v, 32'(sat(exp_ch[3])));
        rd(0, v);  chk("R7 free mode never sets flag", v, 32'h0);

        // R6: disabled monitor does not count
        req_stb = 1'b1; gnt_stb = 1'b1;
        repeat (5) @(negedge clk);
        req_stb = 1'b0; gnt_stb = 1'b0;
        rd(9, v);  chk("R6 no count while disabled", v, 32'(sat(exp_req)));

        // R12: a write to a counter clears only that counter
        wr(9, 32'h0000_DEAD);
        rd(9, v);  chk("R12 request counter cleared", v, 32'h0);
        rd(11, v); chk("R12 other counter kept", v, 32'(sat(exp_ch[0])));
        clear_counts();

        // R7/R8/R10: 20-cycle window, stimulus held for 30 cycles
        wr(15, 20);
        rd(15, v); chk("R12 timer load", v, 32'd20);
        wr(0, 32'h8010_000F);
        req_stb = 1'b1; gnt_stb = 1'b1; gnt_port = 5'd1; gnt_sub = 4'd0;
        repeat (30) @(negedge clk);
        req_stb = 1'b0; gnt_stb = 1'b0;
        rd(9, v);  chk("R7 window length request count", v, 32'd20);
        rd(10, v); chk("R8 grant count held", v, 32'd20);
        rd(11, v); chk("R3 port 1 not in channel 0 mask", v, 32'h0);
        rd(12, v); chk("R4 sub-device 0 in channel 1 mask", v, 32'd20);
        rd(13, v); chk("R5 channel 2 no match", v, 32'h0);
        rd(14, v); chk("R5 channel 3 match", v, 32'd20);
        rd(15, v); chk("R8 timer at zero", v, 32'h0);
        rd(0, v);  chk("R7 flag set at window end", v, 32'hC010_000F);
        chk("R10 irq with flag and enable", {31'b0, irq}, 32'h1);

        // R10/R9: irq gating by enable, write-back clearing
        wr(0, 32'h0010_000F);
        chk("R10 irq low when disabled", {31'b0, irq}, 32'h0);
        rd(0, v);  chk("R9 flag kept on zero write", v, 32'h4010_000F);
        wr(0, 32'h8010_000F);
        chk("R10 irq back on re-enable", {31'b0, irq}, 32'h1);
        wr(0, 32'hC010_000F);
        chk("R9 irq low after clear", {31'b0, irq}, 32'h0);
        rd(0, v);  chk("R9 flag cleared", v, 32'h8010_000F);

        // R7: timer at zero in timer mode counts nothing
        clear_counts();
        req_stb = 1'b1;
        repeat (6) @(negedge clk);
        req_stb = 1'b0;
        rd(9, v);  chk("R7 zero timer counts nothing", v, 32'h0);

        // R7: re-armed short window
        wr(15, 5);
        req_stb = 1'b1;
        repeat (10) @(negedge clk);
        req_stb = 1'b0;
        rd(9, v);  chk("R7 re-armed 5-cycle window", v, 32'd5);
        chk("R10 irq after second window", {31'b0, irq}, 32'h1);

        // R11: request counter saturation in free mode
        wr(0, 32'hC000_0000);
        clear_counts();
        req_stb = 1'b1;
        repeat (300) @(negedge clk);
        req_stb = 1'b0;
        rd(9, v);  chk("R11 request counter saturates", v, 32'(CMAX));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule